// File: doc/BRIEF.md
# Address Translation Unit with Hardware Table Walk

This block turns a virtual address into a physical address. Each request carries a virtual address and an access type, either read or write. The block first looks in a small fully associative translation cache. On a hit it either forms the physical address or reports a protection fault.

On a miss, a hardware walker fetches one page-table entry from memory. The entry's address is a base register plus the page number scaled by the entry size. The walker classifies the entry. A usable entry is written into the cache, and the lookup is retried, so every successful answer comes from a cache hit. An unusable entry ends the request with a fault code.

Only one request is in flight at a time. Each result is presented for a single cycle on a done strobe.

Top module: `xl_mmu`

## Requirements
- R1: The page number is VA[31:12] and the offset is VA[11:0]. On a cache hit whose permissions allow the access, the result has fault code 0 and PA = {PFN, offset}. No memory read is made.
- R2: Fault codes are 0 success, 1 protection, 2 segmentation and 3 page fault. On a cache hit whose permissions forbid the access, the code is 1. On every fault the PA output is 0.
- R3: On a cache miss, exactly one memory read is issued, at address base + page*4. The request stays asserted with a stable address until it is accepted.
- R4: An entry has bit 0 = valid, bit 1 = present, bit 2 = read allowed, bit 3 = write allowed, and bits 31:4 = PFN. A fetched entry with bit 0 clear gives code 2 and is not cached, so a repeat access walks again.
- R5: A valid entry whose permission bit for the access is clear gives code 1. This holds even when its present bit is clear, because the permission check comes before the present check.
- R6: A valid, permitted and present entry is cached and the lookup is retried. The result is code 0 with the PA built from that entry. A later access to the same page hits without a memory read.
- R7: A valid, permitted entry with present clear gives code 3 and is not cached.
- R8: The done strobe lasts exactly one cycle. The request-ready output is low from the cycle after a request is accepted until the cycle in which its result is shown.
- R9: A new translation goes to the lowest-numbered empty slot. When all 8 slots are full, a rotating pointer picks the victim; it starts at slot 0 and advances by one after each replacement. Flush does not move the pointer.
- R10: A one-cycle flush pulse empties every slot, so the next access to any page walks the table.
- R11: After reset, request-ready is 1, done is 0, the memory request is 0 and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empty every cache slot |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| ptbr | input | 32 | Page-table base address |
| rsp_done | output | 1 | One-cycle result strobe |
| rsp_fault | output | 2 | Fault code, 0 = success |
| rsp_pa | output | 40 | Physical address (0 on fault) |
| mem_req_valid | output | 1 | Page-table read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Page-table entry byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Fetched page-table entry |

## Verification
Directed cases cover specific outcomes:
- A page is touched once and then again, which separates a walk followed by insert and retry from a pure hit.
- A page with an invalid entry is accessed twice, which shows that failed walks leave nothing cached.
- One page is given write denied and present clear. A write access and then a read access tell the permission-before-present order apart.
- Nine distinct pages are filled, and a replaced page is then revisited. This exposes the victim order.
- Accesses follow a flush to show that every slot is emptied.

The random phase mixes reads and writes over 64 pages of random entries, with a stalling memory and occasional flushes and table edits. It compares every code, address and walk count against a bench model of the cache.

// File: rtl/xl_pkg.sv
// Shared definitions for the translation unit: fault codes, entry flag
// positions and the permission test. Assumes a two-bit permission field
// where the low bit grants read and the high bit grants write.
package xl_pkg;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_PROT = 2'd1,
        FLT_SEG  = 2'd2,
        FLT_PAGE = 2'd3
    } fault_e;

    localparam int FLAG_W   = 4;
    localparam int BIT_VAL  = 0;
    localparam int BIT_PRES = 1;
    localparam int BIT_RD   = 2;
    localparam int BIT_WR   = 3;

    // Returns 1 when the permission field allows this access type.
    function automatic logic access_ok(input logic [1:0] perm, input logic is_wr);
        return is_wr ? perm[1] : perm[0];
    endfunction

endpackage

// File: rtl/xl_pte_check.sv
// Classifies a fetched page-table entry for one access. The checks run in a
// fixed order: valid first, then permission, then present. Purely combinational.
module xl_pte_check
    import xl_pkg::*;
(
    input  logic [FLAG_W-1:0] pte_flags,
    input  logic              is_wr,
    output logic [1:0]        fault,
    output logic              fill
);

    // Apply the ordered checks and flag a cacheable entry.
    always_comb begin
        fill  = 1'b0;
        fault = FLT_NONE;
        if (!pte_flags[BIT_VAL]) begin
            fault = FLT_SEG;
        end else if (!access_ok(pte_flags[BIT_WR:BIT_RD], is_wr)) begin
            fault = FLT_PROT;
        end else if (!pte_flags[BIT_PRES]) begin
            fault = FLT_PAGE;
        end else begin
            fill = 1'b1;
        end
    end

endmodule

// File: rtl/xl_tlb.sv
// Fully associative translation cache. One combinational lookup port and one
// write port. A write fills the lowest empty slot, or the slot under a
// rotating pointer when all are full. Flush clears all valid bits and wins
// over a write in the same cycle. Assumes the caller never writes a page
// that is already present.
module xl_tlb #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 28,
    parameter int PERM_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_hit,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic [PERM_W-1:0] lk_perm,
    input  logic              wr_en,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic [PERM_W-1:0] wr_perm
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0] slot_v;
    logic [ENTRIES-1:0] match;
    logic [VPN_W-1:0]   slot_vpn  [ENTRIES];
    logic [PFN_W-1:0]   slot_pfn  [ENTRIES];
    logic [PERM_W-1:0]  slot_perm [ENTRIES];
    logic [IDX_W-1:0]   rr_ptr;
    logic [IDX_W-1:0]   victim;
    logic               has_free;

    // Per-slot tag comparators.
    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            assign match[g] = slot_v[g] && (slot_vpn[g] == lk_vpn);
        end
    endgenerate

    assign lk_hit = |match;

    // OR-mux the data of the single matching slot.
    always_comb begin
        lk_pfn  = '0;
        lk_perm = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                lk_pfn  = lk_pfn | slot_pfn[i];
                lk_perm = lk_perm | slot_perm[i];
            end
        end
    end

    // Pick the lowest empty slot, else the rotating pointer.
    always_comb begin
        has_free = 1'b0;
        victim   = rr_ptr;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!slot_v[i]) begin
                has_free = 1'b1;
                victim   = IDX_W'(i);
            end
        end
    end

    // Valid bits and replacement pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_v <= '0;
            rr_ptr <= '0;
        end else if (flush) begin
            slot_v <= '0;
        end else if (wr_en) begin
            slot_v[victim] <= 1'b1;
            if (!has_free) begin
                rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
            end
        end
    end

    // Slot payload storage, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            slot_vpn[victim]  <= wr_vpn;
            slot_pfn[victim]  <= wr_pfn;
            slot_perm[victim] <= wr_perm;
        end
    end

    // R6: a page is never cached twice, so at most one slot matches.
    p_single_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R10: a flush leaves no valid slot behind.
    p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (slot_v == '0));

endmodule

// File: rtl/xl_mmu.sv
// Translation unit top. Accepts one request at a time, looks it up in the
// cache and, on a miss, reads one page-table entry. A usable entry is cached
// and the lookup retried; otherwise a fault is returned. Results are
// registered and shown for one cycle. Assumes memory returns exactly one
// response per accepted read.
module xl_mmu #(
    parameter int VA_W      = 32,
    parameter int OFF_W     = 12,
    parameter int PTE_W     = 32,
    parameter int PTE_BYTES = 4,
    parameter int MA_W      = 32,
    parameter int ENTRIES   = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [VA_W-1:0]               req_va,
    input  logic                          req_write,
    input  logic [MA_W-1:0]               ptbr,
    output logic                          rsp_done,
    output logic [1:0]                    rsp_fault,
    output logic [PTE_W-xl_pkg::FLAG_W+OFF_W-1:0] rsp_pa,
    output logic                          mem_req_valid,
    input  logic                          mem_req_ready,
    output logic [MA_W-1:0]               mem_req_addr,
    input  logic                          mem_rsp_valid,
    input  logic [PTE_W-1:0]              mem_rsp_data
);
    import xl_pkg::*;

    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PFN_W  = PTE_W - FLAG_W;
    localparam int PA_W   = PFN_W + OFF_W;
    localparam int PTE_SH = $clog2(PTE_BYTES);

    typedef enum logic [1:0] {S_IDLE, S_LOOK, S_MREQ, S_MWAIT} state_e;

    state_e            state;
    logic [VA_W-1:0]   va_q;
    logic              wr_q;
    logic [VPN_W-1:0]  vpn;
    logic [OFF_W-1:0]  off;
    logic              tlb_hit;
    logic [PFN_W-1:0]  tlb_pfn;
    logic [1:0]        tlb_perm;
    logic              tlb_wr;
    logic [1:0]        chk_fault;
    logic              chk_fill;

    assign vpn = va_q[VA_W-1:OFF_W];
    assign off = va_q[OFF_W-1:0];

    assign req_ready     = (state == S_IDLE);
    assign mem_req_valid = (state == S_MREQ);
    assign mem_req_addr  = ptbr + MA_W'({vpn, {PTE_SH{1'b0}}});
    assign tlb_wr        = (state == S_MWAIT) && mem_rsp_valid && chk_fill;

    xl_tlb #(
        .ENTRIES(ENTRIES),
        .VPN_W  (VPN_W),
        .PFN_W  (PFN_W),
        .PERM_W (2)
    ) u_tlb (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .lk_vpn (vpn),
        .lk_hit (tlb_hit),
        .lk_pfn (tlb_pfn),
        .lk_perm(tlb_perm),
        .wr_en  (tlb_wr),
        .wr_vpn (vpn),
        .wr_pfn (mem_rsp_data[PTE_W-1:FLAG_W]),
        .wr_perm(mem_rsp_data[BIT_WR:BIT_RD])
    );

    xl_pte_check u_chk (
        .pte_flags(mem_rsp_data[FLAG_W-1:0]),
        .is_wr    (wr_q),
        .fault    (chk_fault),
        .fill     (chk_fill)
    );

    // Control sequence and registered one-cycle result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            va_q      <= '0;
            wr_q      <= 1'b0;
            rsp_done  <= 1'b0;
            rsp_fault <= FLT_NONE;
            rsp_pa    <= '0;
        end else begin
            rsp_done <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        va_q  <= req_va;
                        wr_q  <= req_write;
                        state <= S_LOOK;
                    end
                end
                S_LOOK: begin
                    if (tlb_hit) begin
                        rsp_done <= 1'b1;
                        state    <= S_IDLE;
                        if (access_ok(tlb_perm, wr_q)) begin
                            rsp_fault <= FLT_NONE;
                            rsp_pa    <= {tlb_pfn, off};
                        end else begin
                            rsp_fault <= FLT_PROT;
                            rsp_pa    <= '0;
                        end
                    end else begin
                        state <= S_MREQ;
                    end
                end
                S_MREQ: begin
                    if (mem_req_ready) state <= S_MWAIT;
                end
                S_MWAIT: begin
                    if (mem_rsp_valid) begin
                        if (chk_fill) begin
                            state <= S_LOOK;
                        end else begin
                            rsp_done  <= 1'b1;
                            rsp_fault <= chk_fault;
                            rsp_pa    <= '0;
                            state     <= S_IDLE;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R8: the result strobe never lasts two cycles.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R8: an accepted request blocks the next one.
    p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R3: a stalled table read holds its request and address.
    p_mreq_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R2: a faulting result carries no address.
    p_fault_nopa_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_fault != 2'd0) |-> (rsp_pa == '0));

endmodule

// File: tb/tb_xl_mmu.sv
module tb_xl_mmu;

    localparam logic [31:0] PTBR = 32'h0010_0000;
    localparam int NPG = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        req_write = 1'b0;
    logic        rsp_done;
    logic [1:0]  rsp_fault;
    logic [39:0] rsp_pa;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int checks = 0;
    int errors = 0;
    int walks  = 0;
    logic [31:0] exp_addr = '0;
    logic [31:0] pt [NPG];

    // Bench model of the cache.
    logic        m_v   [8];
    logic [19:0] m_vpn [8];
    logic [27:0] m_pfn [8];
    logic [1:0]  m_perm[8];
    int          m_ptr = 0;

    xl_mmu dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .req_write(req_write), .ptbr(PTBR),
        .rsp_done(rsp_done), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pt_read(input logic [31:0] a);
        logic [31:0] idx = (a - PTBR) >> 2;
        return (idx < NPG) ? pt[idx[5:0]] : 32'h0;
    endfunction

    function automatic logic [1:0] exp_code(input logic [31:0] e, input logic wr);
        if (!e[0]) return 2'd2;
        if (!(wr ? e[3] : e[2])) return 2'd1;
        if (!e[1]) return 2'd3;
        return 2'd0;
    endfunction

    function automatic logic [31:0] mk_pte(input logic [27:0] pfn, input logic w,
                                           input logic r, input logic p, input logic v);
        return {pfn, w, r, p, v};
    endfunction

    // Memory responder with random stalls; checks the read address (R3).
    initial begin
        logic [31:0] a;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_req_ready = ($urandom % 4) != 0;
            @(posedge clk);
            if (mem_req_valid && mem_req_ready) begin
                a = mem_req_addr;
                walks++;
                check("R3 table address", 64'(a), 64'(exp_addr));
                @(negedge clk);
                mem_req_ready = 1'b0;
                repeat ($urandom % 3) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = pt_read(a);
            end
        end
    end

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        for (int i = 0; i < 8; i++) m_v[i] = 1'b0;
    endtask

    // Issue one translation and compare against the model.
    task automatic xlate(input string tag, input logic [31:0] va, input logic wr);
        logic [19:0] vpn = va[31:12];
        logic [31:0] e;
        logic [1:0]  ecode;
        logic [39:0] epa;
        int          ewalk;
        int          hit = -1;
        int          w0;
        int          slot;
        int          n;
        for (int i = 0; i < 8; i++) if (m_v[i] && m_vpn[i] == vpn) hit = i;
        if (hit >= 0) begin
            ewalk = 0;
            ecode = (wr ? m_perm[hit][1] : m_perm[hit][0]) ? 2'd0 : 2'd1;
            epa   = (ecode == 0) ? {m_pfn[hit], va[11:0]} : 40'h0;
        end else begin
            ewalk = 1;
            e     = pt_read(PTBR + {vpn, 2'b00});
            ecode = exp_code(e, wr);
            epa   = (ecode == 0) ? {e[31:4], va[11:0]} : 40'h0;
            if (ecode == 0) begin
                slot = -1;
                for (int i = 7; i >= 0; i--) if (!m_v[i]) slot = i;
                if (slot < 0) begin
                    slot  = m_ptr;
                    m_ptr = (m_ptr + 1) % 8;
                end
                m_v[slot] = 1'b1; m_vpn[slot] = vpn;
                m_pfn[slot] = e[31:4]; m_perm[slot] = e[3:2];
            end
        end
        exp_addr = PTBR + {10'h0, vpn, 2'b00};
        @(negedge clk);
        check({tag, " R8 ready when idle"}, 64'(req_ready), 64'd1);
        w0 = walks;
        req_valid = 1'b1; req_va = va; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!rsp_done && n < 200) begin
            if (req_ready) check({tag, " R8 busy while pending"}, 64'(req_ready), 64'd0);
            @(negedge clk);
            n++;
        end
        check({tag, " done seen"}, 64'(rsp_done), 64'd1);
        check({tag, " code"}, 64'(rsp_fault), 64'(ecode));
        check({tag, " pa"}, 64'(rsp_pa), 64'(epa));
        check({tag, " walk count"}, 64'(walks - w0), 64'(ewalk));
        @(negedge clk);
        check({tag, " R8 one-cycle done"}, 64'(rsp_done), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20231));
        for (int i = 0; i < NPG; i++) pt[i] = $urandom;
        for (int i = 0; i < 8; i++) m_v[i] = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 reset ready", 64'(req_ready), 64'd1);
        check("R11 reset done", 64'(rsp_done), 64'd0);
        check("R11 reset memreq", 64'(mem_req_valid), 64'd0);
        rst_n = 1'b1;

        // R6 then R1: walk, insert, retry; then pure hit.
        pt[5] = mk_pte(28'hABCDE12, 1'b0, 1'b1, 1'b1, 1'b1);
        xlate("R6 first touch", {20'd5, 12'h345}, 1'b0);
        xlate("R1 hit", {20'd5, 12'hFFF}, 1'b0);
        xlate("R2 hit write denied", {20'd5, 12'h001}, 1'b1);
        // R4: invalid entry, not cached.
        pt[6] = mk_pte(28'h1, 1'b1, 1'b1, 1'b1, 1'b0);
        xlate("R4 invalid", {20'd6, 12'h0}, 1'b0);
        xlate("R4 invalid again", {20'd6, 12'h10}, 1'b0);
        // R5 before R7: write denied and not present.
        pt[7] = mk_pte(28'h777, 1'b0, 1'b1, 1'b0, 1'b1);
        xlate("R5 perm before present", {20'd7, 12'h8}, 1'b1);
        xlate("R7 not present", {20'd7, 12'h8}, 1'b0);
        xlate("R7 still uncached", {20'd7, 12'h9}, 1'b0);
        pt[7][1] = 1'b1;
        xlate("R6 after fix", {20'd7, 12'hA}, 1'b0);

        // R10: flush, then the cached page walks again.
        do_flush();
        xlate("R10 walk after flush", {20'd5, 12'h4}, 1'b0);

        // R9: fill all slots, then replace in rotation.
        do_flush();
        for (int p = 10; p < 19; p++) pt[p] = mk_pte(28'(p * 3), 1'b1, 1'b1, 1'b1, 1'b1);
        for (int p = 10; p < 18; p++) xlate("R9 fill", {20'(p), 12'h0}, 1'b1);
        xlate("R9 ninth replaces slot0", {20'd18, 12'h0}, 1'b0);
        xlate("R9 slot1 kept", {20'd11, 12'h0}, 1'b0);
        xlate("R9 slot0 evicted", {20'd10, 12'h0}, 1'b0);
        xlate("R9 slot1 now evicted", {20'd11, 12'h0}, 1'b0);

        // Random phase.
        for (int k = 0; k < 400; k++) begin
            if ($urandom % 40 == 0) do_flush();
            if ($urandom % 25 == 0) pt[$urandom % NPG] = $urandom;
            xlate("rand R1/R2/R4-R7", {20'($urandom % NPG), 12'($urandom)}, 1'($urandom));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule